// File: doc/BRIEF.md
# Shared-Control Performance Counter Unit

This block measures activity inside a processor subsystem. It holds three 32-bit counters. One counts clock cycles and two count selectable events. A single control word governs all three: the global run bit, one-shot clear requests, prescaling of the cycle counter, per-counter interrupt enables, sticky overflow flags and one 8-bit event selector for each event counter.

Event sources present a vector of single-cycle pulses. The vector is indexed by event code, and each event counter watches the pulse that its selector names. Software reads and writes the control word and all three counters through a plain synchronous register port. The port has a write strobe and a combinational read. There is no handshake, so every access completes in the cycle it is presented. When a counter wraps and its interrupt enable is set, the unit holds a level interrupt until software clears the flag.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all three counters read 0, the control word reads 0x0FFFF000 (both selectors 0xFF, every other bit 0), and irq is low.
- R2: While control bit 0 (global enable) is 0, no counter increments.
- R3: With the unit enabled and control bit 3 clear, the cycle counter increments on every clock. With bit 3 set, it increments once every 64 clocks.
- R4: While the unit is enabled, event counter 0 increments on each clock where the event pulse at the code in control bits 19:12 is high. Event counter 1 does the same using the code in control bits 27:20.
- R5: An event counter whose selector is 0xFF never increments, whatever pulses arrive.
- R6: A counter that increments from 0xFFFFFFFF becomes 0 and sets its overflow flag. The flags are control bit 8 (event counter 0), bit 9 (event counter 1) and bit 10 (cycle counter). A flag stays set until software clears it; a later overflow never clears it.
- R7: A control write with a 1 in a flag bit position clears that flag. A 0 in that position leaves the flag unchanged.
- R8: irq is high exactly when some overflow flag is set and its interrupt enable is set. The enables are control bit 4 (event counter 0), bit 5 (event counter 1) and bit 6 (cycle counter).
- R9: Writing 1 to control bit 1 clears both event counters, and writing 1 to bit 2 clears the cycle counter. The clear lands on the clock edge after the write edge. Both bits always read back as 0.
- R10: Control bits 7, 11 and 31:28 always read back as 0, whatever was written to them.
- R11: Register index 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A write to a counter index loads that value. A clear request takes priority over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register index for read and write |
| reg_wr_en | input | 1 | Write strobe, applied on the rising edge |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Combinational read data for reg_addr |
| event_pulse | input | 256 | Event pulses, one bit per event code |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets these corner cases:
- Wraps from 0xFFFFFFFF. A design that forgets the flag or wraps to a wrong value shows it in the counter read and in irq.
- A second overflow while a flag is already set. A design that toggles flags instead of keeping them sticky drops the interrupt.
- Write-one-to-clear writes mixed with other control fields. A design that stores written flag bits would set flags instead of clearing them.
- A clear request that meets a counter write or an event pulse in the same cycle. A wrong priority or wrong timing leaves a nonzero count.
- A selector of 0xFF with every event pulse high. A careless decoder would still count.
- The prescaled cycle counter. An off-by-one divider drifts away from the expected count within a few hundred clocks.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int REG_W    = 32;
  localparam int CODE_W   = 8;
  localparam int N_CNT    = 3;   // 0: event ctr 0, 1: event ctr 1, 2: cycle ctr
  localparam logic [CODE_W-1:0] CODE_IDLE = 8'hFF;

  typedef enum logic [1:0] {
    IDX_CTRL = 2'd0,
    IDX_CYC  = 2'd1,
    IDX_EV0  = 2'd2,
    IDX_EV1  = 2'd3
  } reg_idx_e;

  // control word bit positions
  localparam int B_RUN     = 0;
  localparam int B_CLR_EV  = 1;
  localparam int B_CLR_CY  = 2;
  localparam int B_SLOW    = 3;
  localparam int B_IEN_LO  = 4;
  localparam int B_FLG_LO  = 8;
  localparam int B_SEL0_LO = 12;
  localparam int B_SEL1_LO = 20;

  function automatic reg_idx_e cnt_index(input int k);
    case (k)
      0:       return IDX_EV0;
      1:       return IDX_EV1;
      default: return IDX_CYC;
    endcase
  endfunction
endpackage

// File: rtl/perf_prescale.sv
module perf_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      phase_q <= '0;
    else if (!run)   phase_q <= '0;
    else if (tick)   phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  // R3: two ticks are never adjacent when the period is above one clock
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);
  assign wrap = inc && !clr && !ld && (&q);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + 1'b1;
  end

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !ld && (&q)) |=> (q == '0));

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (q == $past(ld_val)));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import perf_pkg::*;
#(
  parameter int DATA_W       = REG_W,
  parameter int PRESCALE_DIV = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               reg_addr,
  input  logic                     reg_wr_en,
  input  logic [DATA_W-1:0]        reg_wr_data,
  output logic [DATA_W-1:0]        reg_rd_data,
  input  logic [(1<<CODE_W)-1:0]   event_pulse,
  output logic                     irq
);
  localparam int N_EV = N_CNT - 1;

  logic                     run_q, slow_q;
  logic [N_CNT-1:0]         ien_q, flag_q;
  logic [CODE_W-1:0]        sel_q [N_EV];
  logic                     clr_ev_q, clr_cy_q;

  logic [N_CNT-1:0]         inc, clr, ld, wrap;
  logic [DATA_W-1:0]        cnt [N_CNT];
  logic                     slow_tick;
  logic                     ctrl_wr;

  assign ctrl_wr = reg_wr_en && (reg_addr == IDX_CTRL);

  perf_prescale #(.DIV(PRESCALE_DIV)) u_prescale (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q && slow_q),
    .tick (slow_tick)
  );

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    if (k < N_EV) begin : g_ev
      assign inc[k] = run_q && (sel_q[k] != CODE_IDLE) && event_pulse[sel_q[k]];
      assign clr[k] = clr_ev_q;

      p_unused_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[k] == CODE_IDLE && !ld[k] && !clr[k]) |=> $stable(cnt[k]));
    end else begin : g_cy
      assign inc[k] = run_q && (!slow_q || slow_tick);
      assign clr[k] = clr_cy_q;
    end
    assign ld[k] = reg_wr_en && (reg_addr == cnt_index(k));

    perf_counter #(.W(DATA_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr[k]),
      .ld    (ld[k]),
      .ld_val(reg_wr_data),
      .inc   (inc[k]),
      .q     (cnt[k]),
      .wrap  (wrap[k])
    );

    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !ld[k] && !clr[k]) |=> $stable(cnt[k]));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[k] && !(ctrl_wr && reg_wr_data[B_FLG_LO+k])) |=> flag_q[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      slow_q   <= 1'b0;
      ien_q    <= '0;
      flag_q   <= '0;
      clr_ev_q <= 1'b0;
      clr_cy_q <= 1'b0;
      for (int j = 0; j < N_EV; j++) sel_q[j] <= CODE_IDLE;
    end else begin
      clr_ev_q <= ctrl_wr && reg_wr_data[B_CLR_EV];
      clr_cy_q <= ctrl_wr && reg_wr_data[B_CLR_CY];
      if (ctrl_wr) begin
        run_q  <= reg_wr_data[B_RUN];
        slow_q <= reg_wr_data[B_SLOW];
        ien_q  <= reg_wr_data[B_IEN_LO +: N_CNT];
        flag_q <= (flag_q & ~reg_wr_data[B_FLG_LO +: N_CNT]) | wrap;
        sel_q[0] <= reg_wr_data[B_SEL0_LO +: CODE_W];
        sel_q[1] <= reg_wr_data[B_SEL1_LO +: CODE_W];
      end else begin
        flag_q <= flag_q | wrap;
      end
    end
  end

  logic [DATA_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_RUN]                 = run_q;
    ctrl_word[B_SLOW]                = slow_q;
    ctrl_word[B_IEN_LO +: N_CNT]     = ien_q;
    ctrl_word[B_FLG_LO +: N_CNT]     = flag_q;
    ctrl_word[B_SEL0_LO +: CODE_W]   = sel_q[0];
    ctrl_word[B_SEL1_LO +: CODE_W]   = sel_q[1];
  end

  always_comb begin
    case (reg_addr)
      IDX_CTRL: reg_rd_data = ctrl_word;
      IDX_CYC:  reg_rd_data = cnt[2];
      IDX_EV0:  reg_rd_data = cnt[0];
      default:  reg_rd_data = cnt[1];
    endcase
  end

  assign irq = |(flag_q & ien_q);

  logic unused_wr_bits;
  assign unused_wr_bits = ^{reg_wr_data[7], reg_wr_data[11], reg_wr_data[DATA_W-1:28]};
endmodule

// File: tb/perf_mon_unit_bench.sv
`timescale 1ns/1ps
module perf_mon_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   addr = '0;
  logic         we = 1'b0;
  logic [31:0]  wd = '0;
  logic [31:0]  rd;
  logic [255:0] ev = '0;
  logic         irq;

  int checks = 0;
  int errors = 0;
  int wd_cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  perf_mon_unit u_perf_mon_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr_en(we),
    .reg_wr_data(wd), .reg_rd_data(rd), .event_pulse(ev), .irq(irq)
  );

  // reference model, derived from the requirements
  logic        m_run, m_slow, m_ce, m_cc;
  logic [2:0]  m_ien, m_flag, m_wrap;
  logic [7:0]  m_sel [2];
  logic [31:0] m_cnt [3];   // 0 ev0, 1 ev1, 2 cycle
  int          m_ps;

  function automatic logic [1:0] idx_of(input int k);
    return (k == 0) ? 2'd2 : (k == 1) ? 2'd3 : 2'd1;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {4'h0, m_sel[1], m_sel[0], 1'b0, m_flag, 1'b0, m_ien, m_slow, 2'b00, m_run};
      2'd1: return m_cnt[2];
      2'd2: return m_cnt[0];
      default: return m_cnt[1];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_slow = 0; m_ien = 0; m_flag = 0; m_ce = 0; m_cc = 0; m_ps = 0;
      m_sel[0] = 8'hFF; m_sel[1] = 8'hFF;
      for (int k = 0; k < 3; k++) m_cnt[k] = 0;
    end else begin
      logic tk;
      logic [2:0] incv;
      tk = m_run && m_slow && (m_ps == 63);
      incv[0] = m_run && m_sel[0] != 8'hFF && ev[m_sel[0]];
      incv[1] = m_run && m_sel[1] != 8'hFF && ev[m_sel[1]];
      incv[2] = m_run && (!m_slow || tk);
      for (int k = 0; k < 3; k++) begin
        m_wrap[k] = 1'b0;
        if ((k < 2) ? m_ce : m_cc) m_cnt[k] = 0;
        else if (we && addr == idx_of(k)) m_cnt[k] = wd;
        else if (incv[k]) begin
          m_wrap[k] = (m_cnt[k] == 32'hFFFF_FFFF);
          m_cnt[k] = m_cnt[k] + 1;
        end
      end
      m_ps = (m_run && m_slow) ? ((m_ps + 1) % 64) : 0;
      m_ce = we && addr == 0 && wd[1];
      m_cc = we && addr == 0 && wd[2];
      if (we && addr == 0) begin
        m_flag = (m_flag & ~wd[10:8]) | m_wrap;
        m_run = wd[0]; m_slow = wd[3]; m_ien = wd[6:4];
        m_sel[0] = wd[19:12]; m_sel[1] = wd[27:20];
      end else m_flag = m_flag | m_wrap;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, compare read data and irq
  task automatic cyc(input string tag, input logic w, input logic [1:0] a,
                     input logic [31:0] d, input logic [255:0] e);
    @(negedge clk);
    we = w; addr = a; wd = d; ev = e;
    #1;
    chk(tag, rd, m_read(a));
    chk({tag, " irq R8"}, {31'd0, irq}, {31'd0, |(m_flag & m_ien)});
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 4; a++) cyc(tag, 1'b0, 2'(a), 32'd0, 256'd0);
  endtask

  function automatic logic [31:0] ctl(input logic run, input logic slow, input logic [2:0] ien,
                                      input logic [7:0] s0, input logic [7:0] s1);
    return {4'h0, s1, s0, 4'h0, 1'b0, ien, slow, 2'b00, run};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    addr = 2'd0; #1; chk("R1 ctrl reset", rd, 32'h0FFF_F000);
    for (int a = 1; a < 4; a++) begin addr = 2'(a); #1; chk("R1 counter reset", rd, 32'd0); end
    chk("R1 irq reset", {31'd0, irq}, 32'd0);

    // R11: counter load and index map
    cyc("R11 load cyc", 1'b1, 2'd1, 32'h1111_0001, '0);
    cyc("R11 load ev0", 1'b1, 2'd2, 32'h2222_0002, '0);
    cyc("R11 load ev1", 1'b1, 2'd3, 32'h3333_0003, '0);
    rd_all("R11 readback");
    @(negedge clk); addr = 2'd2; #1; chk("R11 ev0 value", rd, 32'h2222_0002);

    // R2: disabled, selectors active, events present
    cyc("R2 program", 1'b1, 2'd0, ctl(0, 0, 3'b000, 8'h07, 8'h05), '0);
    for (int i = 0; i < 20; i++) cyc("R2 idle", 1'b0, 2'(i % 4), 0, {256{1'b1}});
    @(negedge clk); addr = 2'd1; #1; chk("R2 cyc frozen", rd, 32'h1111_0001);

    // R4: selected events count
    cyc("R4 clear", 1'b1, 2'd0, 32'h6 | ctl(1, 0, 3'b000, 8'h07, 8'h05), '0);
    for (int i = 0; i < 40; i++) begin
      logic [255:0] e = '0;
      e[8'h07] = (i % 3 == 0); e[8'h05] = (i % 2 == 0); e[8'h0B] = 1'b1;
      cyc("R4 count", 1'b0, 2'(2 + i % 2), 0, e);
    end
    rd_all("R4 result");

    // R5: unused selector ignores all pulses
    cyc("R5 program", 1'b1, 2'd0, 32'h2 | ctl(1, 0, 3'b000, 8'hFF, 8'h00), '0);
    for (int i = 0; i < 20; i++) cyc("R5 idle", 1'b0, 2'd2, 0, {256{1'b1}});
    @(negedge clk); addr = 2'd2; #1; chk("R5 ev0 unused", rd, 32'd0);

    // R3: prescaled cycle counting
    cyc("R3 clr", 1'b1, 2'd0, 32'h4 | ctl(1, 1, 3'b000, 8'hFF, 8'hFF), '0);
    for (int i = 0; i < 200; i++) cyc("R3 slow", 1'b0, 2'd1, 0, '0);
    cyc("R3 fast", 1'b1, 2'd0, ctl(1, 0, 3'b000, 8'hFF, 8'hFF), '0);
    for (int i = 0; i < 10; i++) cyc("R3 fast run", 1'b0, 2'd1, 0, '0);

    // R6 / R7 / R8: wrap, sticky flag, write-one-to-clear, interrupt
    cyc("R6 arm", 1'b1, 2'd0, ctl(1, 0, 3'b001, 8'h00, 8'hFF), '0);
    cyc("R6 preload", 1'b1, 2'd2, 32'hFFFF_FFFF, '0);
    begin logic [255:0] e = '0; e[0] = 1'b1; cyc("R6 wrap", 1'b0, 2'd2, 0, e); end
    cyc("R6 after", 1'b0, 2'd2, 0, '0);
    @(negedge clk); addr = 2'd2; #1; chk("R6 wrapped zero", rd, 32'd0);
    chk("R8 irq set", {31'd0, irq}, 32'd1);
    cyc("R6 reload", 1'b1, 2'd2, 32'hFFFF_FFFF, '0);
    begin logic [255:0] e = '0; e[0] = 1'b1; cyc("R6 second wrap", 1'b0, 2'd0, 0, e); end
    rd_all("R6 sticky");
    cyc("R7 keep", 1'b1, 2'd0, ctl(1, 0, 3'b001, 8'h00, 8'hFF), '0);
    rd_all("R7 flag kept");
    cyc("R7 clear", 1'b1, 2'd0, 32'h100 | ctl(1, 0, 3'b001, 8'h00, 8'hFF), '0);
    rd_all("R7 flag cleared");

    // R10 / R9: holes and one-shot clears
    cyc("R10 all ones", 1'b1, 2'd0, 32'hFFFF_FFFF, '0);
    @(negedge clk); addr = 2'd0; #1;
    chk("R10 holes zero", rd & 32'hF000_0886, 32'd0);
    chk("R9 clear bits read 0", rd & 32'h6, 32'd0);
    cyc("R9 load", 1'b1, 2'd1, 32'h55, '0);
    cyc("R9 req", 1'b1, 2'd0, 32'h4 | ctl(0, 0, 3'b000, 8'hFF, 8'hFF), '0);
    cyc("R9 same edge load", 1'b1, 2'd1, 32'h77, '0);
    @(negedge clk); addr = 2'd1; #1; chk("R9 cleared", rd, 32'd0);

    // R11 and all: constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic w = ($urandom_range(0, 9) == 0);
      logic [31:0] d = $urandom;
      logic [255:0] e = {$urandom, $urandom, $urandom, $urandom,
                         $urandom, $urandom, $urandom, $urandom};
      if (w && a == 0) begin
        logic [7:0] s0 = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 15));
        logic [7:0] s1 = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 15));
        d = {d[31:28], s1, s0, d[11:8], d[7:4], d[3], ($urandom_range(0, 7) == 0) ? d[2:1] : 2'b00,
             ($urandom_range(0, 4) != 0)};
      end else if (w) d = 32'hFFFF_FF00 | 32'(d[7:0]);
      cyc("R11 random", w, a, d, e);
    end
    done = 1'b1;
  end

  initial begin
    void'($urandom(32'd20240517));
    while (!done && wd_cycles < 150000) begin @(posedge clk); wd_cycles++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule